// File: doc/BRIEF.md
# Reference clock failover controller

This block decides which of four line receivers supplies the master reference clock of a multi-port line card, and what happens when that receiver stops delivering one. A host programs one 8-bit control register. Its 3-bit source field names a receiver, or names none. It also sets the rate code and output enable of a downstream clock synthesizer, and it selects where the transmit clock falls back to when it is lost.

When a receiver is named, the controller drives the shared reference pin with that receiver's clock. When none is named, or a reserved code is written, the pin is released so that another device can drive it. If the named receiver reports carrier loss, the controller moves the reference to the local backup master clock on its own, provided the backup clock is reported valid. If the backup is not valid, it releases the pin and flags that no reference is available. Either condition is latched until the host writes the control register again.

The behaviour is a four-state machine. ST_EXTREF means no local master and the pin is an input. ST_LOCAL means a receiver drives the pin. ST_BACKUP means the backup clock drives the pin after a failover. ST_NOREF means a failover happened with no valid backup. The transitions are as follows. Any control write goes to ST_LOCAL for a port code and to ST_EXTREF for any other code. From ST_LOCAL, carrier loss on the selected port goes to ST_BACKUP when the backup is valid, and to ST_NOREF when it is not. No other transition exists.

Top module: `refclk_failover_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, src_sel is 0, and refpin_oe, syn_oe, jit_alt_en and backup_active are 0. syn_rate and tx_src_sel are 0 as well.
- R2: A host write with host_xcvr = 0 and host_addr = 0x1D stores all 8 bits. Reading that address with host_xcvr = 0 returns exactly the written value in the following cycle, reserved codes included.
- R3: Writes with host_xcvr other than 0, or to any address other than 0x1D, leave the control register and every control output unchanged.
- R4: One clock after a write whose bits [2:0] hold 1, 2, 3 or 4, src_sel equals that code and refpin_oe is 1.
- R5: One clock after a write whose bits [2:0] hold 0, 5, 6 or 7, src_sel is 0 and refpin_oe is 0, with no failover flagged.
- R6: While a receiver is selected, carrier loss on that receiver (rx_carrier_loss bit = code-1) with backup_clk_ok = 1 gives src_sel = 5, refpin_oe = 1 and backup_active = 1 one clock later. Carrier loss on receivers that are not selected has no effect.
- R7: A failover stays in force after the carrier returns. Only a control write (or reset) clears it, and the written code then takes effect.
- R8: Carrier loss on the selected receiver with backup_clk_ok = 0 gives src_sel = 0, refpin_oe = 0 and backup_active = 0 one clock later, with status bit 1 set. This state is latched in the same way as R7.
- R9: When a control write and carrier loss on the currently selected receiver fall in the same cycle, the write wins. If the newly selected receiver is itself in carrier loss, failover follows one clock later.
- R10: One clock after a write, syn_rate equals bits [4:3] (00 = 2.048, 01 = 4.096, 10 = 8.192, 11 = 16.384 MHz), syn_oe equals bit 5 and jit_alt_en equals bit 7.
- R11: tx_src_sel is 00 without transmit clock loss. With tx_clk_loss = 1 it is 01 (backup master clock) when bit 6 is 0, and 10 (system reference) when bit 6 is 1. It follows one clock after its inputs.
- R12: Reading address 0x1E with host_xcvr = 0 returns bit 0 = failover to backup active, bit 1 = failover with no valid backup, and all other bits 0. Reads of any other address or transceiver return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_addr | input | 8 | Host register address |
| host_xcvr | input | 2 | Transceiver index of the access; only 0 reaches this block's registers |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr/host_xcvr |
| rx_carrier_loss | input | 4 | Per-receiver carrier loss, bit i = receiver i+1 |
| tx_clk_loss | input | 1 | Transmit clock loss indication |
| backup_clk_ok | input | 1 | Backup master clock present and valid |
| src_sel | output | 3 | Reference source: 0 none, 1-4 receiver, 5 backup master clock |
| refpin_oe | output | 1 | Shared reference pin drive enable |
| syn_rate | output | 2 | Synthesizer rate code |
| syn_oe | output | 1 | Synthesizer output enable (0 = high impedance) |
| jit_alt_en | output | 1 | Alternate jitter attenuator enable |
| tx_src_sel | output | 2 | Transmit clock fallback source code |
| backup_active | output | 1 | Reference currently taken from the backup clock |

## Verification
A host write to the control register and carrier loss on the currently selected receiver can land on the same clock edge. Both try to move the state machine, one towards a new selection and one towards failover. The bench drives the write strobe and the loss bits in the same low phase of the clock. It expects the new selection on src_sel after that edge, with no failover. When the new receiver is also in loss, it expects failover exactly one edge later. The case is repeated with a reserved code, where the loss must then be ignored.

// File: rtl/refclk_pkg.sv
package refclk_pkg;

    // Source-selection state of the reference clock controller
    typedef enum logic [1:0] {
        ST_EXTREF = 2'd0,   // no local master, shared pin is an input
        ST_LOCAL  = 2'd1,   // a selected receiver drives the shared pin
        ST_BACKUP = 2'd2,   // failover latched, backup clock drives the pin
        ST_NOREF  = 2'd3    // failover latched, no valid backup available
    } src_state_t;

    // Control register layout (bit 7 down to bit 0)
    typedef struct packed {
        logic       jit_alt_en;  // bit 7
        logic       bkp_sel;     // bit 6: tx clock fallback target
        logic       syn_oe;      // bit 5
        logic [1:0] syn_rate;    // bits 4:3
        logic [2:0] src_code;    // bits 2:0
    } ctrl_reg_t;

    localparam logic [2:0] SRC_NONE   = 3'd0;
    localparam logic [2:0] SRC_BACKUP = 3'd5;

    localparam logic [1:0] TXS_OWN    = 2'b00;
    localparam logic [1:0] TXS_BACKUP = 2'b01;
    localparam logic [1:0] TXS_SYSREF = 2'b10;

    // True when a source code names one of n receivers
    function automatic logic code_is_port(input logic [2:0] c, input int n);
        return (c != 3'd0) && (int'(c) <= n);
    endfunction

endpackage

// File: rtl/refclk_host_regs.sv
module refclk_host_regs
    import refclk_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          XCVR_W    = 2,
    parameter logic [7:0]  CTRL_ADDR = 8'h1D,
    parameter logic [7:0]  STAT_ADDR = 8'h1E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [XCVR_W-1:0] host_xcvr,
    input  logic [7:0]        host_wdata,
    input  logic              stat_backup,
    input  logic              stat_noref,
    output ctrl_reg_t         ctrl_q,
    output ctrl_reg_t         ctrl_d,
    output logic              ctrl_we,
    output logic [7:0]        host_rdata
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    logic owner_sel;

    // Only transceiver index 0 owns this register set
    assign owner_sel = (host_xcvr == '0);
    assign ctrl_we   = host_wr && owner_sel && (host_addr == CTRL_A);

    // Next register value, also used for same-edge output updates
    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_we) begin
            ctrl_d = ctrl_reg_t'(host_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // Read mux
    always_comb begin
        host_rdata = 8'h00;
        if (owner_sel) begin
            if (host_addr == CTRL_A) begin
                host_rdata = ctrl_q;
            end else if (host_addr == STAT_A) begin
                host_rdata = {6'b0, stat_noref, stat_backup};
            end
        end
    end

    // R3: register changes only through a decoded write
    assert_hold_unless_written_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> $stable(ctrl_q)
    ) else $error("control register changed without a write");

    // R2: a decoded write lands in the register exactly
    assert_write_lands_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (ctrl_q == $past(host_wdata))
    ) else $error("control write not stored");

endmodule

// File: rtl/refclk_loss_pick.sv
module refclk_loss_pick #(
    parameter int N_RX = 4
) (
    input  logic [N_RX-1:0] rx_loss,
    input  logic [2:0]      src_code,
    output logic            sel_lost
);

    logic [N_RX-1:0] hit;

    // One comparator per receiver: loss counts only for the selected port
    for (genvar i = 0; i < N_RX; i++) begin : g_port
        localparam logic [2:0] PORT_CODE = 3'(i + 1);
        assign hit[i] = rx_loss[i] && (src_code == PORT_CODE);
    end

    assign sel_lost = |hit;

    // At most one port can match a single code
    always_comb begin
        assert_single_hit_R6: assert ($onehot0(hit))
            else $error("more than one port matched the source code");
    end

endmodule

// File: rtl/refclk_src_fsm.sv
module refclk_src_fsm
    import refclk_pkg::*;
#(
    parameter int N_RX = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  ctrl_reg_t  ctrl_d,
    input  logic       sel_lost,
    input  logic       backup_ok,
    input  logic       tx_clk_loss,
    output logic [2:0] src_sel,
    output logic       refpin_oe,
    output logic [1:0] syn_rate,
    output logic       syn_oe,
    output logic       jit_alt_en,
    output logic [1:0] tx_src_sel,
    output logic       backup_active,
    output logic       noref_flag
);

    src_state_t state_q, state_d;

    // Next-state logic: a host write always wins over a carrier-loss event
    always_comb begin
        state_d = state_q;
        if (ctrl_we) begin
            state_d = code_is_port(ctrl_d.src_code, N_RX) ? ST_LOCAL : ST_EXTREF;
        end else begin
            unique case (state_q)
                ST_LOCAL: begin
                    if (sel_lost) begin
                        state_d = backup_ok ? ST_BACKUP : ST_NOREF;
                    end
                end
                ST_EXTREF, ST_BACKUP, ST_NOREF: begin
                    state_d = state_q;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EXTREF;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs, decoded from next state and next register value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_sel       <= SRC_NONE;
            refpin_oe     <= 1'b0;
            syn_rate      <= 2'b00;
            syn_oe        <= 1'b0;
            jit_alt_en    <= 1'b0;
            tx_src_sel    <= TXS_OWN;
            backup_active <= 1'b0;
            noref_flag    <= 1'b0;
        end else begin
            unique case (state_d)
                ST_EXTREF: begin
                    src_sel       <= SRC_NONE;
                    refpin_oe     <= 1'b0;
                    backup_active <= 1'b0;
                    noref_flag    <= 1'b0;
                end
                ST_LOCAL: begin
                    src_sel       <= ctrl_d.src_code;
                    refpin_oe     <= 1'b1;
                    backup_active <= 1'b0;
                    noref_flag    <= 1'b0;
                end
                ST_BACKUP: begin
                    src_sel       <= SRC_BACKUP;
                    refpin_oe     <= 1'b1;
                    backup_active <= 1'b1;
                    noref_flag    <= 1'b0;
                end
                ST_NOREF: begin
                    src_sel       <= SRC_NONE;
                    refpin_oe     <= 1'b0;
                    backup_active <= 1'b0;
                    noref_flag    <= 1'b1;
                end
            endcase
            syn_rate   <= ctrl_d.syn_rate;
            syn_oe     <= ctrl_d.syn_oe;
            jit_alt_en <= ctrl_d.jit_alt_en;
            if (!tx_clk_loss) begin
                tx_src_sel <= TXS_OWN;
            end else if (ctrl_d.bkp_sel) begin
                tx_src_sel <= TXS_SYSREF;
            end else begin
                tx_src_sel <= TXS_BACKUP;
            end
        end
    end

    // R4: a port code written selects that port and drives the pin
    assert_port_select_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (ctrl_we && code_is_port(ctrl_d.src_code, N_RX))
            |=> (src_sel == $past(ctrl_d.src_code)) && refpin_oe && !backup_active
    ) else $error("port selection not applied");

    // R5: a none/reserved code releases the pin
    assert_release_pin_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (ctrl_we && !code_is_port(ctrl_d.src_code, N_RX))
            |=> (src_sel == SRC_NONE) && !refpin_oe && !backup_active && !noref_flag
    ) else $error("pin not released for none/reserved code");

    // R6: backup in use always drives the pin with the backup code
    assert_backup_drives_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        backup_active |-> (refpin_oe && src_sel == SRC_BACKUP)
    ) else $error("backup active without driving backup source");

    // R7: failover is latched until a control write
    assert_failover_latched_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (backup_active && !ctrl_we) |=> backup_active
    ) else $error("failover cleared without a write");

    // R8: no-reference condition keeps the pin released until a write
    assert_noref_latched_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (noref_flag && !ctrl_we) |=> (noref_flag && !refpin_oe)
    ) else $error("no-reference condition not held");

    // R11: tx fallback code never takes the unused value
    assert_tx_code_legal_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        tx_src_sel != 2'b11
    ) else $error("illegal tx fallback code");

endmodule

// File: rtl/refclk_failover_ctrl.sv
module refclk_failover_ctrl
    import refclk_pkg::*;
#(
    parameter int          N_RX      = 4,
    parameter int          ADDR_W    = 8,
    parameter int          XCVR_W    = 2,
    parameter logic [7:0]  CTRL_ADDR = 8'h1D,
    parameter logic [7:0]  STAT_ADDR = 8'h1E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [XCVR_W-1:0] host_xcvr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic [N_RX-1:0]   rx_carrier_loss,
    input  logic              tx_clk_loss,
    input  logic              backup_clk_ok,
    output logic [2:0]        src_sel,
    output logic              refpin_oe,
    output logic [1:0]        syn_rate,
    output logic              syn_oe,
    output logic              jit_alt_en,
    output logic [1:0]        tx_src_sel,
    output logic              backup_active
);

    ctrl_reg_t ctrl_q;
    ctrl_reg_t ctrl_d;
    logic      ctrl_we;
    logic      sel_lost;
    logic      noref_flag;

    refclk_host_regs #(
        .ADDR_W    (ADDR_W),
        .XCVR_W    (XCVR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .STAT_ADDR (STAT_ADDR)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr),
        .host_addr   (host_addr),
        .host_xcvr   (host_xcvr),
        .host_wdata  (host_wdata),
        .stat_backup (backup_active),
        .stat_noref  (noref_flag),
        .ctrl_q      (ctrl_q),
        .ctrl_d      (ctrl_d),
        .ctrl_we     (ctrl_we),
        .host_rdata  (host_rdata)
    );

    refclk_loss_pick #(
        .N_RX (N_RX)
    ) u_pick (
        .rx_loss  (rx_carrier_loss),
        .src_code (ctrl_q.src_code),
        .sel_lost (sel_lost)
    );

    refclk_src_fsm #(
        .N_RX (N_RX)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_we       (ctrl_we),
        .ctrl_d        (ctrl_d),
        .sel_lost      (sel_lost),
        .backup_ok     (backup_clk_ok),
        .tx_clk_loss   (tx_clk_loss),
        .src_sel       (src_sel),
        .refpin_oe     (refpin_oe),
        .syn_rate      (syn_rate),
        .syn_oe        (syn_oe),
        .jit_alt_en    (jit_alt_en),
        .tx_src_sel    (tx_src_sel),
        .backup_active (backup_active),
        .noref_flag    (noref_flag)
    );

    // R12: status readback never reports both failover flavours
    assert_status_exclusive_R12: assert property (
        @(posedge clk) disable iff (!rst_n)
        !(backup_active && noref_flag)
    ) else $error("both failover flags set");

endmodule

// File: tb/test_refclk_failover_ctrl.sv
module test_refclk_failover_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL = 8'h1D;
    localparam logic [7:0] A_STAT = 8'h1E;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_addr = 8'h00;
    logic [1:0] host_xcvr = 2'b00;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [3:0] rx_carrier_loss = 4'b0000;
    logic       tx_clk_loss = 1'b0;
    logic       backup_clk_ok = 1'b1;
    logic [2:0] src_sel;
    logic       refpin_oe;
    logic [1:0] syn_rate;
    logic       syn_oe;
    logic       jit_alt_en;
    logic [1:0] tx_src_sel;
    logic       backup_active;

    int n_vec = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refclk_failover_ctrl i_refclk_failover_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .host_wr         (host_wr),
        .host_addr       (host_addr),
        .host_xcvr       (host_xcvr),
        .host_wdata      (host_wdata),
        .host_rdata      (host_rdata),
        .rx_carrier_loss (rx_carrier_loss),
        .tx_clk_loss     (tx_clk_loss),
        .backup_clk_ok   (backup_clk_ok),
        .src_sel         (src_sel),
        .refpin_oe       (refpin_oe),
        .syn_rate        (syn_rate),
        .syn_oe          (syn_oe),
        .jit_alt_en      (jit_alt_en),
        .tx_src_sel      (tx_src_sel),
        .backup_active   (backup_active)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Write one register; returns at the falling edge after the capture edge
    task automatic wr(input logic [7:0] a, input logic [1:0] x, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_xcvr = x; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] x, output logic [7:0] d);
        host_addr = a; host_xcvr = x;
        #1;
        d = host_rdata;
    endtask

    function automatic logic [2:0] exp_src(input logic [2:0] c);
        return (c >= 3'd1 && c <= 3'd4) ? c : 3'd0;
    endfunction

    task automatic chk_state(input string req, input logic [2:0] s, input logic oe,
                             input logic bk, input logic [7:0] stat);
        logic [7:0] r;
        chk(req, {5'b0, src_sel}, {5'b0, s});
        chk(req, {7'b0, refpin_oe}, {7'b0, oe});
        chk(req, {7'b0, backup_active}, {7'b0, bk});
        rd(A_STAT, 2'd0, r);
        chk({req, " R12"}, r, stat);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(A_CTRL, 2'd0, r);
        chk("R1 ctrl", r, 8'h00);
        chk_state("R1", 3'd0, 1'b0, 1'b0, 8'h00);
        chk("R1 rate/oe/jit/tx", {2'b0, syn_rate, syn_oe, jit_alt_en, tx_src_sel}, 8'h00);

        // R2 R4 R5 R10: sweep every control value
        for (int v = 0; v < 256; v++) begin
            wr(A_CTRL, 2'd0, 8'(v));
            rd(A_CTRL, 2'd0, r);
            chk("R2 readback", r, 8'(v));
            chk_state((exp_src(3'(v)) != 0) ? "R4" : "R5",
                      exp_src(3'(v)), exp_src(3'(v)) != 0, 1'b0, 8'h00);
            chk("R10 rate", {6'b0, syn_rate}, {6'b0, 2'(v >> 3)});
            chk("R10 syn_oe", {7'b0, syn_oe}, {7'b0, 1'(v >> 5)});
            chk("R10 jit", {7'b0, jit_alt_en}, {7'b0, 1'(v >> 7)});
        end

        // R3: accesses to other transceivers or addresses are ignored
        wr(A_CTRL, 2'd0, 8'h03);
        for (int x = 1; x < 4; x++) begin
            wr(A_CTRL, 2'(x), 8'hFF);
            rd(A_CTRL, 2'd0, r);
            chk("R3 xcvr", r, 8'h03);
            chk("R3 xcvr out", {syn_oe, jit_alt_en, syn_rate, 1'b0, src_sel}, 8'h03);
            rd(A_CTRL, 2'(x), r);
            chk("R12 other xcvr read", r, 8'h00);
        end
        for (int a = 0; a < 32; a++) begin
            if (8'(a) != A_CTRL) begin
                wr(8'(a), 2'd0, 8'hFC);
                rd(A_CTRL, 2'd0, r);
                chk("R3 addr", r, 8'h03);
                chk("R3 addr out", {5'b0, src_sel}, 8'h03);
            end
        end

        // R6 R7 R8: selected port x lost port x backup validity
        for (int s = 1; s <= 4; s++) begin
            for (int l = 0; l < 4; l++) begin
                for (int ok = 0; ok < 2; ok++) begin
                    wr(A_CTRL, 2'd0, 8'(s));
                    backup_clk_ok = 1'(ok);
                    rx_carrier_loss = 4'(1 << l);
                    @(negedge clk);
                    if (l == s - 1) begin
                        if (ok == 1) chk_state("R6 failover", 3'd5, 1'b1, 1'b1, 8'h01);
                        else         chk_state("R8 noref", 3'd0, 1'b0, 1'b0, 8'h02);
                    end else begin
                        chk_state("R6 unselected", 3'(s), 1'b1, 1'b0, 8'h00);
                    end
                    rx_carrier_loss = 4'b0000;
                    backup_clk_ok = 1'b1;
                    repeat (2) @(negedge clk);
                    if (l == s - 1) begin
                        if (ok == 1) chk_state("R7 latched", 3'd5, 1'b1, 1'b1, 8'h01);
                        else         chk_state("R8 latched", 3'd0, 1'b0, 1'b0, 8'h02);
                        wr(A_CTRL, 2'd1, 8'(s));
                        chk_state("R3 R7 foreign write", (ok == 1) ? 3'd5 : 3'd0,
                                  ok == 1, ok == 1, (ok == 1) ? 8'h01 : 8'h02);
                        wr(A_CTRL, 2'd0, 8'(s));
                        chk_state("R7 cleared", 3'(s), 1'b1, 1'b0, 8'h00);
                    end else begin
                        chk_state("R6 unselected hold", 3'(s), 1'b1, 1'b0, 8'h00);
                    end
                end
            end
        end

        // R9: write collides with carrier loss on old and new ports
        wr(A_CTRL, 2'd0, 8'h01);
        @(negedge clk);
        host_wr = 1'b1; host_addr = A_CTRL; host_xcvr = 2'd0; host_wdata = 8'h02;
        rx_carrier_loss = 4'b0011;
        @(negedge clk);
        host_wr = 1'b0;
        chk_state("R9 write wins", 3'd2, 1'b1, 1'b0, 8'h00);
        @(negedge clk);
        chk_state("R9 then failover", 3'd5, 1'b1, 1'b1, 8'h01);
        rx_carrier_loss = 4'b0000;

        // R9: collision with a reserved code leaves the pin released
        wr(A_CTRL, 2'd0, 8'h04);
        @(negedge clk);
        host_wr = 1'b1; host_wdata = 8'h06;
        rx_carrier_loss = 4'b1000;
        @(negedge clk);
        host_wr = 1'b0;
        chk_state("R9 reserved wins", 3'd0, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        chk_state("R9 reserved hold", 3'd0, 1'b0, 1'b0, 8'h00);
        rx_carrier_loss = 4'b0000;

        // R11: tx clock fallback target
        for (int b = 0; b < 2; b++) begin
            for (int t = 0; t < 2; t++) begin
                wr(A_CTRL, 2'd0, 8'(b << 6) | 8'h01);
                tx_clk_loss = 1'(t);
                chk("R11 pre", {6'b0, tx_src_sel}, 8'h00);
                @(negedge clk);
                chk("R11 fallback", {6'b0, tx_src_sel},
                    (t == 0) ? 8'h00 : ((b == 1) ? 8'h02 : 8'h01));
                tx_clk_loss = 1'b0;
                @(negedge clk);
                chk("R11 release", {6'b0, tx_src_sel}, 8'h00);
            end
        end

        // R1: reset during a latched failover
        wr(A_CTRL, 2'd0, 8'hE1);
        rx_carrier_loss = 4'b0001;
        @(negedge clk);
        rx_carrier_loss = 4'b0000;
        do_reset();
        rd(A_CTRL, 2'd0, r);
        chk("R1 ctrl after reset", r, 8'h00);
        chk_state("R1 after reset", 3'd0, 1'b0, 1'b0, 8'h00);
        chk("R1 rate/oe/jit/tx after", {2'b0, syn_rate, syn_oe, jit_alt_en, tx_src_sel}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule